// File: doc/BRIEF.md
# Charger Operating Mode and Register Reset Controller

This block decides whether a battery charger may charge, whether it sits in high-impedance mode, and when its configuration registers must return to their defaults. It holds a small register bank written through a single-cycle write strobe, a tick-driven watchdog, and the policy that combines the host's high-impedance bit, an external disable pin, the watchdog-disable bit, a valid-supply flag and a battery-below-low-threshold comparator. Status outputs follow their inputs in the same cycle, with no filtering.

The host configures the block through the write port and reads it back through a combinational read port. What a high-impedance request does depends on two things: whether the watchdog is enabled and whether the battery is low. The request can pause the watchdog, let it run on to overflow, or clear the registers at once. A register clear never touches the safety-limit register. That register also caps every value written to a parameter register.

Top module: `chg_mode_ctrl`

## Requirements
- R1: After `rst_n` is released, the register values are as follows. Address 0 (control) reads 0x01: bit 0 is the charge-disable bit and is 1, bit 1 is the high-impedance bit and is 0. Address 1 (watchdog config, bit 0 = watchdog disable) reads 0x00. Addresses 2 to 4 (parameters) read 0x10. Address 5 (safety limit) reads 0x3C. Addresses 6 and 7 read 0x00.
- R2: A write to address 0 with bit 7 set is a reset command. At the next edge it returns every register except the safety limit to its R1 value. `reg_rst_o` is high during the cycle after each edge at which a register clear takes effect.
- R3: The charge-disable bit after a reset command is 0 only if `vbus_ok` and `vbat_low` were both 1 in the cycle of the command. Otherwise it is 1. Every other kind of clear sets it to 1.
- R4: `hz_mode` is the OR of the high-impedance bit and `dis_pin`. While it is high, `state` is standby and `chg_en` is low.
- R5: With the watchdog disabled and `vbat_low` low, a high-impedance request only stops charging. Removing the request resumes charging, and the registers are unchanged.
- R6: With the watchdog disabled, a high-impedance request while `vbat_low` is high clears the registers at the next edge. This holds whether the request comes first or the battery falls first.
- R7: With the watchdog enabled and `vbat_low` low, a high-impedance request drives `wd_run` low. The watchdog count holds its value, and counting continues from that value once the request is removed.
- R8: With the watchdog enabled and `vbat_low` high, a high-impedance request leaves `wd_run` high, so the watchdog can overflow and clear the registers.
- R9: The watchdog advances on each cycle with `tick` high while `wd_run` is high. Any write, or a set watchdog-disable bit, returns it to zero. On the 32nd counted tick it overflows, which clears the registers, provided no write occurs in that cycle.
- R10: A write to a parameter address stores the smaller of the written data and the current safety-limit value. The safety-limit register changes only by a direct write or by `rst_n`.
- R11: `state` encodes standby as 0, idle as 1 and charge as 2. It is standby when `vbus_ok` is low or `hz_mode` is high, charge when `chg_en` is high, and idle otherwise. `chg_en` is `vbus_ok` and not `hz_mode` and not the charge-disable bit.
- R12: `chg_en`, `hz_mode`, `wd_run` and `state` respond combinationally to `dis_pin`, `vbus_ok` and `vbat_low`, within the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, clears all registers including safety |
| wr_en | input | 1 | Single-cycle write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Combinational read data |
| dis_pin | input | 1 | External disable request |
| vbus_ok | input | 1 | Input supply valid |
| vbat_low | input | 1 | Battery below low-voltage threshold |
| tick | input | 1 | Watchdog time base strobe |
| reg_rst_o | output | 1 | Register clear strobe, one cycle after the clearing edge |
| chg_en | output | 1 | Charger enable |
| hz_mode | output | 1 | High-impedance mode flag |
| wd_run | output | 1 | Watchdog is counting |
| state | output | 2 | Standby / idle / charge |

## Verification
`chg_en`, `hz_mode`, `wd_run` and `state` are due in the same cycle as the input or register value that drives them. Register contents, including clamped parameters and the charge-disable value after a command, change at the first edge after the write or clear condition, and `reg_rst_o` follows one cycle after that edge. A watchdog overflow is due at the edge of its 32nd counted tick. The bench's reference model advances at each rising edge from the inputs held during that cycle, and the bench compares every output at the following falling edge, so each result is checked in the cycle it is due.

// File: rtl/chg_pkg.sv
`timescale 1ns/1ps
package chg_pkg;
   typedef enum logic [1:0] {
      CHG_STANDBY = 2'd0,
      CHG_IDLE    = 2'd1,
      CHG_ACTIVE  = 2'd2
   } chg_state_e;

   localparam int unsigned ADDR_CTRL    = 0;
   localparam int unsigned ADDR_WDCFG   = 1;
   localparam int unsigned ADDR_PARAM0  = 2;
   localparam int unsigned CTRL_CEN_BIT = 0;
   localparam int unsigned CTRL_HZ_BIT  = 1;
   localparam int unsigned WDCFG_DIS_BIT = 0;
endpackage

// File: rtl/chg_regbank.sv
`timescale 1ns/1ps
module chg_regbank #(
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned NUM_REGS = 6,
   parameter int unsigned ADDR_W   = 3,
   parameter logic [DATA_W-1:0] PARAM_RST = 'h10,
   parameter logic [DATA_W-1:0] SAFE_RST  = 'h3C,
   parameter bit CLAMP_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic              soft_rst,
   input  logic              cen_after_rst,
   output logic              rst_cmd,
   output logic              ce_n,
   output logic              hz_bit,
   output logic              wd_dis,
   output logic [DATA_W-1:0] rd_data
);
   import chg_pkg::*;

   localparam int unsigned NUM_PARAM = NUM_REGS - 3;
   localparam int unsigned SAFE_ADDR = NUM_REGS - 1;
   localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(ADDR_CTRL);
   localparam logic [ADDR_W-1:0] A_WDCFG = ADDR_W'(ADDR_WDCFG);
   localparam logic [ADDR_W-1:0] A_SAFE  = ADDR_W'(SAFE_ADDR);

   logic              ce_n_q, hz_q, wd_dis_q;
   logic [DATA_W-1:0] safety_q;
   logic [DATA_W-1:0] param_q [NUM_PARAM];
   logic [DATA_W-1:0] wr_param;

   assign rst_cmd = wr_en && (wr_addr == A_CTRL) && wr_data[DATA_W-1];

   // variant: capped parameter writes or plain storage
   generate
      if (CLAMP_EN) begin : g_clamp
         assign wr_param = (wr_data > safety_q) ? safety_q : wr_data;
      end else begin : g_plain
         assign wr_param = wr_data;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ce_n_q <= 1'b1;
         hz_q   <= 1'b0;
      end else if (soft_rst) begin
         ce_n_q <= cen_after_rst;
         hz_q   <= 1'b0;
      end else if (wr_en && (wr_addr == A_CTRL)) begin
         ce_n_q <= wr_data[CTRL_CEN_BIT];
         hz_q   <= wr_data[CTRL_HZ_BIT];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         wd_dis_q <= 1'b0;
      else if (soft_rst)
         wd_dis_q <= 1'b0;
      else if (wr_en && (wr_addr == A_WDCFG))
         wd_dis_q <= wr_data[WDCFG_DIS_BIT];
   end

   // safety limit: untouched by register clears
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         safety_q <= SAFE_RST;
      else if (wr_en && (wr_addr == A_SAFE))
         safety_q <= wr_data;
   end

   generate
      for (genvar i = 0; i < NUM_PARAM; i++) begin : g_param
         localparam logic [ADDR_W-1:0] A_ME = ADDR_W'(ADDR_PARAM0 + i);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               param_q[i] <= PARAM_RST;
            else if (soft_rst)
               param_q[i] <= PARAM_RST;
            else if (wr_en && (wr_addr == A_ME))
               param_q[i] <= wr_param;
         end
      end
   endgenerate

   always_comb begin
      rd_data = '0;
      if (rd_addr == A_CTRL) begin
         rd_data[CTRL_CEN_BIT] = ce_n_q;
         rd_data[CTRL_HZ_BIT]  = hz_q;
      end else if (rd_addr == A_WDCFG) begin
         rd_data[WDCFG_DIS_BIT] = wd_dis_q;
      end else if (rd_addr == A_SAFE) begin
         rd_data = safety_q;
      end else begin
         for (int k = 0; k < int'(NUM_PARAM); k++) begin
            if (rd_addr == ADDR_W'(ADDR_PARAM0 + k))
               rd_data = param_q[k];
         end
      end
   end

   assign ce_n   = ce_n_q;
   assign hz_bit = hz_q;
   assign wd_dis = wd_dis_q;
endmodule

// File: rtl/chg_wdog.sv
`timescale 1ns/1ps
module chg_wdog #(
   parameter int unsigned WD_LIMIT = 32,
   parameter int unsigned CNT_W    = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             run,
   input  logic             tick,
   output logic [CNT_W-1:0] cnt,
   output logic             ovf
);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(WD_LIMIT - 1);

   logic [CNT_W-1:0] cnt_q;

   assign ovf = run && tick && !clr && (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (clr || ovf)
         cnt_q <= '0;
      else if (run && tick)
         cnt_q <= cnt_q + 1'b1;
   end

   assign cnt = cnt_q;
endmodule

// File: rtl/chg_policy.sv
`timescale 1ns/1ps
module chg_policy (
   input  logic              ce_n,
   input  logic              hz_bit,
   input  logic              wd_dis,
   input  logic              dis_pin,
   input  logic              vbus_ok,
   input  logic              vbat_low,
   input  logic              rst_cmd,
   input  logic              wd_ovf,
   output logic              hz_req,
   output logic              wd_run,
   output logic              soft_rst,
   output logic              cen_after_rst,
   output logic              chg_en,
   output chg_pkg::chg_state_e state
);
   import chg_pkg::*;

   logic hz_low_rst;

   assign hz_req        = hz_bit || dis_pin;
   // watchdog off + low battery: a high-impedance request clears at once
   assign hz_low_rst    = wd_dis && vbat_low && hz_req;
   // watchdog on + healthy battery: a high-impedance request pauses the timer
   assign wd_run        = !wd_dis && !(hz_req && !vbat_low);
   assign soft_rst      = rst_cmd || hz_low_rst || wd_ovf;
   assign cen_after_rst = !(rst_cmd && vbus_ok && vbat_low);
   assign chg_en        = vbus_ok && !hz_req && !ce_n;

   always_comb begin
      if (!vbus_ok || hz_req)
         state = CHG_STANDBY;
      else if (chg_en)
         state = CHG_ACTIVE;
      else
         state = CHG_IDLE;
   end
endmodule

// File: rtl/chg_mode_ctrl.sv
`timescale 1ns/1ps
module chg_mode_ctrl #(
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned NUM_REGS = 6,
   parameter int unsigned WD_LIMIT = 32,
   parameter logic [DATA_W-1:0] PARAM_RST = 'h10,
   parameter logic [DATA_W-1:0] SAFE_RST  = 'h3C,
   parameter bit CLAMP_EN = 1'b1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  logic [$clog2(NUM_REGS+2)-1:0] wr_addr,
   input  logic [DATA_W-1:0]             wr_data,
   input  logic [$clog2(NUM_REGS+2)-1:0] rd_addr,
   output logic [DATA_W-1:0]             rd_data,
   input  logic                          dis_pin,
   input  logic                          vbus_ok,
   input  logic                          vbat_low,
   input  logic                          tick,
   output logic                          reg_rst_o,
   output logic                          chg_en,
   output logic                          hz_mode,
   output logic                          wd_run,
   output logic [1:0]                    state
);
   import chg_pkg::*;

   localparam int unsigned ADDR_W = $clog2(NUM_REGS + 2);
   localparam int unsigned CNT_W  = (WD_LIMIT > 1) ? $clog2(WD_LIMIT) : 1;

   generate
      if (DATA_W < 4) begin : g_bad_width
         $error("DATA_W must be at least 4");
      end
      if (NUM_REGS < 4) begin : g_bad_regs
         $error("NUM_REGS must be at least 4");
      end
      if (WD_LIMIT < 2) begin : g_bad_limit
         $error("WD_LIMIT must be at least 2");
      end
      if (PARAM_RST > SAFE_RST) begin : g_bad_defaults
         $error("PARAM_RST must not exceed SAFE_RST");
      end
   endgenerate

   logic             ce_n, hz_bit, wd_dis, rst_cmd;
   logic             hz_req, soft_rst, cen_after_rst, wd_ovf;
   logic [CNT_W-1:0] wd_cnt;
   chg_state_e       state_e;
   logic             reg_rst_q;

   chg_regbank #(
      .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W),
      .PARAM_RST(PARAM_RST), .SAFE_RST(SAFE_RST), .CLAMP_EN(CLAMP_EN)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .soft_rst(soft_rst),
      .cen_after_rst(cen_after_rst), .rst_cmd(rst_cmd), .ce_n(ce_n),
      .hz_bit(hz_bit), .wd_dis(wd_dis), .rd_data(rd_data)
   );

   chg_wdog #(.WD_LIMIT(WD_LIMIT), .CNT_W(CNT_W)) u_wdog (
      .clk(clk), .rst_n(rst_n), .clr(wr_en || wd_dis), .run(wd_run),
      .tick(tick), .cnt(wd_cnt), .ovf(wd_ovf)
   );

   chg_policy u_policy (
      .ce_n(ce_n), .hz_bit(hz_bit), .wd_dis(wd_dis), .dis_pin(dis_pin),
      .vbus_ok(vbus_ok), .vbat_low(vbat_low), .rst_cmd(rst_cmd),
      .wd_ovf(wd_ovf), .hz_req(hz_req), .wd_run(wd_run),
      .soft_rst(soft_rst), .cen_after_rst(cen_after_rst),
      .chg_en(chg_en), .state(state_e)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         reg_rst_q <= 1'b0;
      else
         reg_rst_q <= soft_rst;
   end

   assign reg_rst_o = reg_rst_q;
   assign hz_mode   = hz_req;
   assign state     = state_e;
endmodule

// File: rtl/chg_mode_chk.sv
`timescale 1ns/1ps
module chg_mode_chk #(
   parameter int unsigned CNT_W    = 5,
   parameter int unsigned WD_LIMIT = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic             vbus_ok,
   input logic             vbat_low,
   input logic             chg_en,
   input logic             hz_mode,
   input logic             wd_run,
   input logic [1:0]       state,
   input logic             reg_rst_o,
   input logic             hz_bit,
   input logic             wd_dis,
   input logic             soft_rst,
   input logic [CNT_W-1:0] wd_cnt
);
   // R11: charging needs a good supply and no high-impedance request
   a_r11_chg_needs_supply: assert property (@(posedge clk) disable iff (!rst_n)
      chg_en |-> (vbus_ok && !hz_mode && state == 2'd2));

   // R4: high-impedance forces standby
   a_r4_hz_standby: assert property (@(posedge clk) disable iff (!rst_n)
      hz_mode |-> (state == 2'd0 && !chg_en));

   // R2: after a clear, mode bits read back at defaults
   a_r2_clear_defaults: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rst_o |-> (!hz_bit && !wd_dis));

   // R6: watchdog off, low battery, request -> clear next cycle
   a_r6_immediate_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (wd_dis && vbat_low && hz_mode) |=> reg_rst_o);

   // R7: a paused watchdog keeps its count
   a_r7_count_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (!wd_run && !wr_en && !soft_rst) |=> $stable(wd_cnt));

   // R9: any write restarts the watchdog
   a_r9_write_restart: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (wd_cnt == '0));

   // R9: count never reaches the limit
   a_r9_count_range: assert property (@(posedge clk) disable iff (!rst_n)
      (32'(wd_cnt) < WD_LIMIT));
endmodule

bind chg_mode_ctrl chg_mode_chk #(.CNT_W(CNT_W), .WD_LIMIT(WD_LIMIT)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .vbus_ok(vbus_ok),
   .vbat_low(vbat_low), .chg_en(chg_en), .hz_mode(hz_mode),
   .wd_run(wd_run), .state(state), .reg_rst_o(reg_rst_o),
   .hz_bit(hz_bit), .wd_dis(wd_dis), .soft_rst(soft_rst), .wd_cnt(wd_cnt)
);

// File: tb/tb_chg_mode_ctrl.sv
`timescale 1ns/1ps
module tb_chg_mode_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [2:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [2:0] rd_addr = '0;
   logic [7:0] rd_data;
   logic       dis_pin = 1'b0, vbus_ok = 1'b0, vbat_low = 1'b0, tick = 1'b0;
   logic       reg_rst_o, chg_en, hz_mode, wd_run;
   logic [1:0] state;

   int errors = 0;
   int checks = 0;
   string scen = "R1 reset";

   always #2 clk = ~clk;

   chg_mode_ctrl dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .dis_pin(dis_pin), .vbus_ok(vbus_ok), .vbat_low(vbat_low),
      .tick(tick), .reg_rst_o(reg_rst_o), .chg_en(chg_en),
      .hz_mode(hz_mode), .wd_run(wd_run), .state(state)
   );

   // behavioural reference model
   bit m_cen = 1, m_hz = 0, m_wdd = 0, m_rstq = 0;
   int m_par [3] = '{16, 16, 16};
   int m_safe = 60;
   int m_cnt = 0;

   function automatic bit f_hzreq();
      return m_hz || dis_pin;
   endfunction

   function automatic bit f_run();
      return !m_wdd && !(f_hzreq() && !vbat_low);
   endfunction

   function automatic int f_read(int a);
      case (a)
         0: return {m_hz, m_cen};
         1: return m_wdd;
         2, 3, 4: return m_par[a-2];
         5: return m_safe;
         default: return 0;
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cen = 1; m_hz = 0; m_wdd = 0; m_rstq = 0;
         m_par = '{16, 16, 16}; m_safe = 60; m_cnt = 0;
      end else begin
         bit cmd, hzrst, run, clr, ovf, srst;
         int old_safe;
         cmd   = wr_en && wr_addr == 0 && wr_data[7];
         hzrst = m_wdd && vbat_low && f_hzreq();
         run   = f_run();
         clr   = wr_en || m_wdd;
         ovf   = run && tick && !clr && m_cnt == 31;
         srst  = cmd || hzrst || ovf;
         old_safe = m_safe;
         if (clr || ovf) m_cnt = 0;
         else if (run && tick) m_cnt = m_cnt + 1;
         if (srst) begin
            m_cen = !(cmd && vbus_ok && vbat_low);
            m_hz = 0; m_wdd = 0; m_par = '{16, 16, 16};
         end else if (wr_en) begin
            case (wr_addr)
               0: begin m_cen = wr_data[0]; m_hz = wr_data[1]; end
               1: m_wdd = wr_data[0];
               2, 3, 4: m_par[wr_addr-2] = (wr_data > old_safe) ? old_safe : wr_data;
               default: ;
            endcase
         end
         if (wr_en && wr_addr == 5) m_safe = wr_data;
         m_rstq = srst;
      end
   end

   task automatic chk(string tag, string name, int act, int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s [%s] %s: got %0h expected %0h", tag, scen, name, act, exp);
      end
   endtask

   // compare at every falling edge, away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         bit hzr, en;
         int st;
         hzr = f_hzreq();
         en  = vbus_ok && !hzr && !m_cen;
         st  = (!vbus_ok || hzr) ? 0 : (en ? 2 : 1);
         chk("R11", "chg_en", chg_en, en);
         chk("R4", "hz_mode", hz_mode, hzr);
         chk("R7", "wd_run", wd_run, f_run());
         chk("R11", "state", state, st);
         chk("R2", "reg_rst_o", reg_rst_o, m_rstq);
         chk("R10", "rd_data", rd_data, f_read(rd_addr));
      end
   end

   // sweep the read port over every address
   always @(posedge clk) begin
      #1 rd_addr = rd_addr + 1'b1;
   end

   task automatic cyc(int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk); #1;
         wr_en = 0; tick = 0;
      end
   endtask

   task automatic wr(int a, int d);
      @(posedge clk); #1;
      wr_en = 1; wr_addr = 3'(a); wr_data = 8'(d); tick = 0;
      @(posedge clk); #1;
      wr_en = 0;
   endtask

   task automatic ticks(int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk); #1;
         wr_en = 0; tick = 1;
      end
      @(posedge clk); #1;
      tick = 0;
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog: run did not complete, got hung expected done");
      finish_run();
   end

   initial begin
      cyc(3);
      rst_n = 1;
      @(negedge clk);
      // R1: explicit reset-state checks
      chk("R1", "chg_en_rst", chg_en, 0);
      chk("R1", "state_rst", state, 0);
      chk("R1", "reg_rst_rst", reg_rst_o, 0);
      cyc(10);

      scen = "R10 clamp";
      wr(2, 'h50); wr(3, 'h20); wr(5, 'h18); wr(4, 'h7F); wr(3, 'h19);
      cyc(9);

      scen = "R11 charge idle standby";
      vbus_ok = 1; cyc(3);
      wr(0, 'h00); cyc(4);
      vbus_ok = 0; cyc(2); vbus_ok = 1; cyc(2);

      scen = "R12 raw dis_pin";
      dis_pin = 1; cyc(1); dis_pin = 0; cyc(1); dis_pin = 1; cyc(2); dis_pin = 0; cyc(2);

      scen = "R5 wd off hz resume";
      wr(1, 1); wr(0, 'h02); cyc(4); wr(0, 'h00); cyc(3);
      dis_pin = 1; cyc(3); dis_pin = 0; cyc(3);
      scen = "R6 battery falls in hz";
      wr(0, 'h02); cyc(2); vbat_low = 1; cyc(3); vbat_low = 0; cyc(3);

      scen = "R6 immediate clear";
      wr(1, 1); vbat_low = 1; cyc(2); wr(0, 'h02); cyc(4);
      wr(1, 1); dis_pin = 1; cyc(3); dis_pin = 0; vbat_low = 0; cyc(3);

      scen = "R3 command clears";
      vbat_low = 1; wr(0, 'h80); cyc(3);
      vbat_low = 0; wr(0, 'h80); cyc(3);
      vbus_ok = 0; vbat_low = 1; wr(0, 'h80); cyc(3);
      vbus_ok = 1; vbat_low = 0;

      scen = "R2 command keeps safety";
      wr(5, 'h30); wr(2, 'h22); wr(4, 'h05); wr(0, 'h00); cyc(8);
      wr(0, 'h81); cyc(8);

      scen = "R9 watchdog restart and overflow";
      wr(0, 'h00); ticks(20); wr(2, 'h11); ticks(31); cyc(3); ticks(2); cyc(3);
      wr(0, 'h00); ticks(31); wr(3, 3); ticks(33); cyc(3);
      wr(1, 1); ticks(40); cyc(3);

      scen = "R7 hz pauses watchdog";
      wr(1, 0); wr(0, 'h00); ticks(10); dis_pin = 1; ticks(40);
      dis_pin = 0; ticks(21); cyc(2); ticks(2); cyc(3);

      scen = "R8 low battery hz lets watchdog run";
      vbat_low = 1; wr(0, 'h02); ticks(34); cyc(3);
      dis_pin = 1; ticks(33); dis_pin = 0; vbat_low = 0; cyc(4);

      finish_run();
   end
endmodule